// File: doc/BRIEF.md
# Counter Event Flag Generator

This block turns the event pulses of a position counter into two status pins. The first pin, `flga_n`, is active low. It can carry any mix of four sources: overflow (carry), underflow (borrow), a compare match and the index level. A configuration bit chooses how it behaves. In latched mode the pin stays low once any enabled source fires and releases only on a clear strobe. In pass-through mode the pin follows the enabled sources in the same cycle.

A compare match only counts in certain conditions. In the free-running and single-cycle count modes it counts in either direction. In the range-limit and modulo modes it counts only while the counter runs upward.

The second pin, `flgb`, reports one of three things, picked by a two-bit select:
- a sign bit that the block tracks from borrow and carry pulses,
- the present count direction,
- a fixed high level.

Event generation and register access are outside this block. The counter core drives the event and configuration pins directly. There is no streaming data path, so all pins are plain level or pulse signals with no handshake.

Top module: `evt_flag_unit`

## Requirements
- R1: After reset, with no events, `flga_n` is 1 in both FLGa modes, and the tracked sign is 0, so `flgb` is 0 when the select is 01.
- R2: `src_en` bit 0 enables carry, bit 1 enables borrow, bit 2 enables compare and bit 3 enables index on FLGa. Any combination may be set, and a source whose bit is 0 has no effect on `flga_n`.
- R3: In count modes 00 (free-running) and 01 (single-cycle), a compare pulse is a valid source whether `cnt_up` is 1 or 0.
- R4: In count modes 10 (range-limit) and 11 (modulo), a compare pulse is a valid source only when `cnt_up` is 1.
- R5: The index source is a level. While `index_lvl` is 1 and bit 3 of `src_en` is set, FLGa treats index as active.
- R6: With `flga_pass` = 1, `flga_n` is 0 in the same cycle as any enabled, valid source and 1 otherwise, with no clock involved.
- R7: With `flga_pass` = 0, `flga_n` goes low at the first rising edge after an enabled, valid source. It stays low until a rising edge that samples `flag_clr` = 1 with no valid source, and it is high after that edge.
- R8: If a valid source and `flag_clr` are sampled at the same edge, `flga_n` is low after that edge.
- R9: Any edge sampled with `flga_pass` = 1 empties the latch. After returning to `flga_pass` = 0 with no events, `flga_n` is 1.
- R10: `flgb_sel` selects `flgb`, combinationally: 00 gives 1, 11 gives 1, 01 gives the sign bit, and 10 gives `cnt_up`.
- R11: The sign bit becomes 1 at the edge after a borrow pulse and 0 at the edge after a carry pulse. If both pulses arrive together, the sign bit is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| carry_pls | input | 1 | Counter overflow pulse, one cycle |
| borrow_pls | input | 1 | Counter underflow pulse, one cycle |
| match_pls | input | 1 | Counter-equals-preset pulse, one cycle |
| index_lvl | input | 1 | Index input at its active level |
| cnt_up | input | 1 | Count direction, 1 = up |
| cnt_mode | input | 2 | 00 free-running, 01 single-cycle, 10 range-limit, 11 modulo |
| src_en | input | 4 | FLGa source enables {index, compare, borrow, carry} |
| flga_pass | input | 1 | 1 = FLGa pass-through, 0 = latched |
| flag_clr | input | 1 | Release strobe for the latched FLGa |
| flgb_sel | input | 2 | FLGb source select |
| flga_n | output | 1 | Combined event flag, active low |
| flgb | output | 1 | Sign / direction / high flag |

## Verification
The block's results arrive at two different times.
- Zero cycles: pass-through FLGa and every `flgb` select are combinational. The bench checks them one time unit after it drives the inputs on the falling edge, with no clock edge in between.
- One edge: the latched FLGa and the sign bit each pass through one register. The bench drives a pulse for exactly one cycle, lets the next rising edge sample it, and reads the result at the following falling edge.

This one-edge rule also covers the same-edge race between an event and `flag_clr`, and the emptying of the latch while pass-through mode is selected.

// File: rtl/evt_flag_pkg.sv
package evt_flag_pkg;
  localparam int SRC_N     = 4;
  localparam int SRC_CARRY = 0;
  localparam int SRC_BORW  = 1;
  localparam int SRC_MATCH = 2;
  localparam int SRC_INDEX = 3;
  localparam int MODE_W    = 2;
  localparam int SEL_W     = 2;

  typedef enum logic [MODE_W-1:0] {
    CM_FREE    = 2'b00,
    CM_ONESHOT = 2'b01,
    CM_RANGE   = 2'b10,
    CM_MODULO  = 2'b11
  } cnt_mode_e;

  typedef enum logic [SEL_W-1:0] {
    FB_HIGH = 2'b00,
    FB_SIGN = 2'b01,
    FB_DIR  = 2'b10,
    FB_RSVD = 2'b11
  } flgb_sel_e;
endpackage

// File: rtl/evt_qualify.sv
module evt_qualify
  import evt_flag_pkg::*;
#(
  parameter int N = SRC_N
) (
  input  logic [N-1:0]      ev_raw,
  input  logic [N-1:0]      en,
  input  logic [MODE_W-1:0] mode,
  input  logic              up,
  output logic [N-1:0]      ev_hit,
  output logic              any_hit
);
  cnt_mode_e mode_e;
  logic      match_ok;
  logic [N-1:0] ev_valid;

  assign mode_e = cnt_mode_e'(mode);

  // compare counts both ways only in free-running and single-cycle modes
  always_comb begin
    unique case (mode_e)
      CM_FREE, CM_ONESHOT: match_ok = 1'b1;
      default:             match_ok = up;
    endcase
  end

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_src
      if (gi == SRC_MATCH) begin : g_match
        assign ev_valid[gi] = ev_raw[gi] & match_ok;
      end else begin : g_plain
        assign ev_valid[gi] = ev_raw[gi];
      end
      assign ev_hit[gi] = ev_valid[gi] & en[gi];
    end
  endgenerate

  assign any_hit = |ev_hit;
endmodule

// File: rtl/flga_hold.sv
module flga_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr,
  input  logic pass,
  output logic held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held <= 1'b0;
    else if (pass) held <= 1'b0;
    else if (hit)  held <= 1'b1;
    else if (clr)  held <= 1'b0;
  end

  assert_set_on_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass && hit) |=> held);
  assert_event_beats_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass && hit && clr) |=> held);
  assert_clr_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !held);
  assert_pass_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pass |=> !held);
endmodule

// File: rtl/sign_track.sv
module sign_track (
  input  logic clk,
  input  logic rst_n,
  input  logic carry,
  input  logic borrow,
  output logic neg
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                neg <= 1'b0;
    else if (borrow && !carry) neg <= 1'b1;
    else if (carry && !borrow) neg <= 1'b0;
  end

  assert_borrow_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (borrow && !carry) |=> neg);
  assert_carry_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (carry && !borrow) |=> !neg);
  assert_both_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (carry && borrow) |=> $stable(neg));
endmodule

// File: rtl/evt_flag_unit.sv
module evt_flag_unit
  import evt_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              carry_pls,
  input  logic              borrow_pls,
  input  logic              match_pls,
  input  logic              index_lvl,
  input  logic              cnt_up,
  input  logic [MODE_W-1:0] cnt_mode,
  input  logic [SRC_N-1:0]  src_en,
  input  logic              flga_pass,
  input  logic              flag_clr,
  input  logic [SEL_W-1:0]  flgb_sel,
  output logic              flga_n,
  output logic              flgb
);
  logic [SRC_N-1:0] ev_raw;
  logic [SRC_N-1:0] ev_hit;
  logic             any_hit;
  logic             held;
  logic             neg;
  flgb_sel_e        sel_e;

  always_comb begin
    ev_raw             = '0;
    ev_raw[SRC_CARRY]  = carry_pls;
    ev_raw[SRC_BORW]   = borrow_pls;
    ev_raw[SRC_MATCH]  = match_pls;
    ev_raw[SRC_INDEX]  = index_lvl;
  end

  evt_qualify #(.N(SRC_N)) u_qual (
    .ev_raw  (ev_raw),
    .en      (src_en),
    .mode    (cnt_mode),
    .up      (cnt_up),
    .ev_hit  (ev_hit),
    .any_hit (any_hit)
  );

  flga_hold u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (any_hit),
    .clr   (flag_clr),
    .pass  (flga_pass),
    .held  (held)
  );

  sign_track u_sign (
    .clk    (clk),
    .rst_n  (rst_n),
    .carry  (carry_pls),
    .borrow (borrow_pls),
    .neg    (neg)
  );

  assign flga_n = flga_pass ? ~any_hit : ~held;

  assign sel_e = flgb_sel_e'(flgb_sel);
  always_comb begin
    unique case (sel_e)
      FB_SIGN: flgb = neg;
      FB_DIR:  flgb = cnt_up;
      default: flgb = 1'b1;
    endcase
  end

  assert_match_blocked_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flga_pass && cnt_mode[1] && !cnt_up && src_en == 4'b0100) |-> flga_n);
  assert_disabled_src_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flga_pass && src_en == '0) |-> flga_n);
  assert_pass_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flga_pass && carry_pls && src_en[SRC_CARRY]) |-> !flga_n);
  assert_flgb_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flgb_sel == 2'b00 || flgb_sel == 2'b11) |-> flgb);
  assert_index_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flga_pass && index_lvl && src_en[SRC_INDEX]) |-> !flga_n);
  assert_hit_onehot_idx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en == 4'b1000) |-> $onehot0(ev_hit));
endmodule

// File: tb/tb_evt_flag_unit.sv
module tb_evt_flag_unit;
  localparam int CLK_P = 10;
  localparam int NV = 14;
  // {mode[1:0], up, en{idx,cmp,bor,car}, ev{idx,cmp,bor,car}, exp_flga_n}
  localparam logic [11:0] VEC [NV] = '{
    {2'b00, 1'b0, 4'b0001, 4'b0001, 1'b0}, // R2 carry enabled
    {2'b00, 1'b0, 4'b0000, 4'b1111, 1'b1}, // R2 nothing enabled
    {2'b00, 1'b0, 4'b0010, 4'b0001, 1'b1}, // R2 carry not routed
    {2'b00, 1'b0, 4'b0010, 4'b0010, 1'b0}, // R2 borrow enabled
    {2'b00, 1'b0, 4'b0100, 4'b0100, 1'b0}, // R3 free, down
    {2'b01, 1'b1, 4'b0100, 4'b0100, 1'b0}, // R3 single-cycle, up
    {2'b10, 1'b0, 4'b0100, 4'b0100, 1'b1}, // R4 range, down
    {2'b10, 1'b1, 4'b0100, 4'b0100, 1'b0}, // R4 range, up
    {2'b11, 1'b0, 4'b0100, 4'b0100, 1'b1}, // R4 modulo, down
    {2'b11, 1'b1, 4'b0100, 4'b0100, 1'b0}, // R4 modulo, up
    {2'b00, 1'b0, 4'b1000, 4'b1000, 1'b0}, // R5 index level
    {2'b00, 1'b0, 4'b1011, 4'b0100, 1'b1}, // R2 compare not routed
    {2'b11, 1'b0, 4'b1111, 4'b0100, 1'b1}, // R4 all enabled, down match
    {2'b11, 1'b0, 4'b1111, 4'b0101, 1'b0}  // R2 mix, carry wins
  };

  logic clk = 0, rst_n = 0;
  logic carry_pls = 0, borrow_pls = 0, match_pls = 0, index_lvl = 0;
  logic cnt_up = 0, flga_pass = 0, flag_clr = 0;
  logic [1:0] cnt_mode = 0, flgb_sel = 0;
  logic [3:0] src_en = 0;
  logic flga_n, flgb;
  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  evt_flag_unit dut (
    .clk(clk), .rst_n(rst_n), .carry_pls(carry_pls), .borrow_pls(borrow_pls),
    .match_pls(match_pls), .index_lvl(index_lvl), .cnt_up(cnt_up),
    .cnt_mode(cnt_mode), .src_en(src_en), .flga_pass(flga_pass),
    .flag_clr(flag_clr), .flgb_sel(flgb_sel), .flga_n(flga_n), .flgb(flgb)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic evs(input logic [3:0] e);
    {index_lvl, match_pls, borrow_pls, carry_pls} = e;
  endtask

  task automatic edge_then_idle();
    @(negedge clk);
    evs(4'b0000);
    flag_clr = 0;
    #1;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    flgb_sel = 2'b01;
    repeat (2) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 flga_n after reset", flga_n, 1'b1);
    chk("R1 sign after reset", flgb, 1'b0);

    // table walk in pass-through mode
    flga_pass = 1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {cnt_mode, cnt_up, src_en} = VEC[i][11:5];
      evs(VEC[i][4:1]);
      #1;
      chk($sformatf("R6 vector %0d", i), flga_n, VEC[i][0]);
    end
    @(negedge clk);
    evs(4'b0000);
    #1;
    chk("R6 idle", flga_n, 1'b1);

    // latched mode
    @(negedge clk);
    flga_pass = 0; cnt_mode = 2'b00; src_en = 4'b0001;
    #1;
    chk("R1 latched idle", flga_n, 1'b1);
    @(negedge clk); evs(4'b0010);          // borrow, not enabled
    edge_then_idle();
    chk("R2 unrouted borrow no latch", flga_n, 1'b1);
    @(negedge clk); evs(4'b0001);
    #1;
    chk("R7 not yet latched before edge", flga_n, 1'b1);
    edge_then_idle();
    chk("R7 latched after edge", flga_n, 1'b0);
    @(negedge clk); #1;
    chk("R7 holds", flga_n, 1'b0);
    flag_clr = 1;
    edge_then_idle();
    chk("R7 released by clear", flga_n, 1'b1);

    @(negedge clk); evs(4'b0001); flag_clr = 1;
    edge_then_idle();
    chk("R8 event beats clear", flga_n, 1'b0);

    @(negedge clk); flga_pass = 1;
    @(negedge clk); flga_pass = 0;
    #1;
    chk("R9 latch emptied by pass-through", flga_n, 1'b1);

    // index level latched
    @(negedge clk); src_en = 4'b1000; index_lvl = 1;
    @(negedge clk); @(negedge clk); #1;
    chk("R5 index level latched", flga_n, 1'b0);
    index_lvl = 0; flag_clr = 1;
    edge_then_idle();
    chk("R5 cleared after index drops", flga_n, 1'b1);

    // compare qualification latched
    @(negedge clk); src_en = 4'b0100; cnt_mode = 2'b10; cnt_up = 0; evs(4'b0100);
    edge_then_idle();
    chk("R4 range down no latch", flga_n, 1'b1);

    // FLGb select and sign tracking
    flgb_sel = 2'b01;
    @(negedge clk); evs(4'b0010);
    #1;
    chk("R11 sign before edge", flgb, 1'b0);
    edge_then_idle();
    chk("R11 borrow sets sign", flgb, 1'b1);
    @(negedge clk); evs(4'b0011);
    edge_then_idle();
    chk("R11 both keeps sign", flgb, 1'b1);
    @(negedge clk); evs(4'b0001);
    edge_then_idle();
    chk("R11 carry clears sign", flgb, 1'b0);
    @(negedge clk); evs(4'b0011);
    edge_then_idle();
    chk("R11 both keeps clear sign", flgb, 1'b0);

    flgb_sel = 2'b00; #1;
    chk("R10 sel 00 high", flgb, 1'b1);
    flgb_sel = 2'b11; #1;
    chk("R10 sel 11 high", flgb, 1'b1);
    flgb_sel = 2'b10; cnt_up = 1; #1;
    chk("R10 dir up", flgb, 1'b1);
    cnt_up = 0; #1;
    chk("R10 dir down", flgb, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule